// File: doc/BRIEF.md
# DMA Controller Register File

This block is the register bank of a ten-channel DMA controller. It stores each channel's set of configuration words and the controller's global words. It also keeps one combined status and mask word that is never simply overwritten. A host reaches every register through a single 32-bit port that has an address, a write strobe, write data and combinational read data. The transfer engine that sits next to the bank does not write through that port. Instead it raises single-cycle event inputs: a channel finished, a stall, the MFIFO ran empty, or a bus error. Each event sets its flag in the status word. One interrupt output combines the flags with their masks.

The low half of the status word holds event flags. The host clears a flag by writing a 1 to it. The high half holds enable masks. The host inverts a mask bit by writing a 1 to it. In both halves a written 0 has no effect. This lets software acknowledge one event, or flip one enable, without a read-modify-write sequence. When an event and a clear reach the same flag in the same cycle, the event is kept.

Top module: `dmac_regfile`

## Requirements
- R1: After reset every channel word, every global word and the status word read as zero, and `irq` is low.
- R2: Channel c (0 to 9) occupies byte address `c*0x100`, with register slot k at offset `k*0x10`. Address bit 15 is 0 and bits 14:12 and 3:0 are zero. The slots are: 0 control, 1 transfer address, 2 quadword count, 3 tag address, 4 and 5 saved tag addresses, 6 and 7 padding, 8 scratchpad address. Slots 0, 1, 2 and 8 store and return all 32 written bits.
- R3: Slots 3, 4 and 5 keep a 30-bit address in bits 29:0 and a memory-select flag in bit 30. Bit 31 always reads 0.
- R4: Padding slots 6 and 7, slots 9 to 15, channels 10 to 15 and any address with a nonzero ignored bit all read 0. Writes to them change no register.
- R5: Global word g sits at byte address `0x8000 + g*0x10`, with bits 14:7 and 3:0 zero. The words are: 0 control, 1 status, 2 priority control, 3 stall quadword count, 4 ring size, 5 ring offset, 6 stall address. Every word except status is a plain 32-bit read/write word. Slot 7 reads 0.
- R6: Status bits 9:0 are the channel flags, bit 13 is stall, bit 14 is MFIFO empty and bit 15 is bus error. Writing 1 to any of bits 15:0 clears that bit. Writing 0 leaves it unchanged.
- R7: Status bits 25:16 are the channel masks, bit 29 is the stall mask and bit 30 is the MFIFO mask. Writing 1 to any of bits 31:16 inverts that bit. Writing 0 leaves it unchanged.
- R8: Reserved status bits 12:10, 28:26 and 31 always read 0, whatever is written.
- R9: An asserted `ev_chan_done[c]`, `ev_stall`, `ev_mfifo_empty` or `ev_bus_err` sets the matching flag on the next edge. If a write-one-clear hits the same bit in that cycle, the bit ends set.
- R10: `irq` is high exactly when some channel flag and its mask are both set, or stall flag and stall mask are both set, or MFIFO flag and MFIFO mask are both set. The bus error flag never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_chan_done | input | 10 | Per-channel completion events |
| ev_stall | input | 1 | Stall event |
| ev_mfifo_empty | input | 1 | MFIFO empty event |
| ev_bus_err | input | 1 | Bus error event |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks a distinct pattern through every channel slot and global word. This exposes aliasing between channels, a tag word that keeps bit 31, and padding that stores data. It then writes to unmapped addresses and reads everything back, so a loose decoder shows up as corrupted neighbours.

On the status word, the bench sweeps one-hot writes across all 32 bits. A design that overwrites, toggles the flags or clears the masks diverges on the first write. Reserved bits that stick at 1 show up in the same sweep. Per-source interrupt sweeps catch a swapped mask bit and a bus error that wrongly drives `irq`. A clear that lands in the same cycle as its event catches a design where the clear wins.

// File: rtl/dmac_rf_pkg.sv
package dmac_rf_pkg;

  localparam int unsigned DW         = 32;
  localparam int unsigned NREG       = 9;   // slots per channel block
  localparam int unsigned NGLOB      = 7;   // global words
  localparam int unsigned GSTAT_IDX  = 1;   // status slot among globals
  localparam int unsigned STALL_BIT  = 13;
  localparam int unsigned MFIFO_BIT  = 14;
  localparam int unsigned BERR_BIT   = 15;
  localparam int unsigned MASK_LSB   = 16;
  localparam int unsigned STALL_MSK  = 29;
  localparam int unsigned MFIFO_MSK  = 30;

  // Bits of the status word that hold state.
  function automatic logic [DW-1:0] stat_valid(int unsigned nch);
    logic [DW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nch; i++) begin
      m[i]            = 1'b1;
      m[MASK_LSB + i] = 1'b1;
    end
    m[STALL_BIT] = 1'b1;
    m[MFIFO_BIT] = 1'b1;
    m[BERR_BIT]  = 1'b1;
    m[STALL_MSK] = 1'b1;
    m[MFIFO_MSK] = 1'b1;
    return m;
  endfunction

  // Storage mask of a channel slot.
  function automatic logic [DW-1:0] slot_keep(int unsigned k);
    if (k == 6 || k == 7)             return '0;
    if (k == 3 || k == 4 || k == 5)   return 32'h7FFF_FFFF;
    return '1;
  endfunction

  // Next status: clear-by-one low half, toggle-by-one high half, sets win.
  function automatic logic [DW-1:0] stat_next(logic [DW-1:0] cur, logic wr,
                                              logic [DW-1:0] wdata,
                                              logic [DW-1:0] setv,
                                              int unsigned nch);
    logic [15:0] clr, tog;
    logic [DW-1:0] n;
    clr = wr ? wdata[15:0]  : 16'h0;
    tog = wr ? wdata[31:16] : 16'h0;
    n   = {cur[31:16] ^ tog, cur[15:0] & ~clr};
    n   = n | setv;
    return n & stat_valid(nch);
  endfunction

  function automatic logic stat_irq(logic [DW-1:0] cur, int unsigned nch);
    logic hit;
    hit = 1'b0;
    for (int unsigned i = 0; i < nch; i++)
      hit = hit | (cur[i] & cur[MASK_LSB + i]);
    hit = hit | (cur[STALL_BIT] & cur[STALL_MSK]);
    hit = hit | (cur[MFIFO_BIT] & cur[MFIFO_MSK]);
    return hit;
  endfunction

endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
  import dmac_rf_pkg::*;
#(
  parameter int unsigned NCH = 10,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned RSW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] ch_sel,
  input  logic [RSW-1:0] reg_sel,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);

  localparam int unsigned NWORD = NCH * NREG;

  logic [NWORD*DW-1:0] flat;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar k = 0; k < NREG; k++) begin : g_slot
      localparam logic [DW-1:0] KEEP = slot_keep(k);
      logic [DW-1:0] q;
      logic          hit;
      assign hit = wr_en && (ch_sel == CHW'(c)) && (reg_sel == RSW'(k));
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata & KEEP;
      end
      assign flat[(c*NREG + k)*DW +: DW] = q & KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < int'(NCH); c++)
      for (int k = 0; k < int'(NREG); k++)
        if (ch_sel == CHW'(c) && reg_sel == RSW'(k))
          rdata = flat[(c*NREG + k)*DW +: DW];
  end

endmodule

// File: rtl/dmac_glob_regs.sv
module dmac_glob_regs
  import dmac_rf_pkg::*;
#(
  localparam int unsigned GSW = $clog2(NGLOB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [GSW-1:0] g_sel,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);

  logic [NGLOB*DW-1:0] flat;

  for (genvar g = 0; g < NGLOB; g++) begin : g_word
    if (g == GSTAT_IDX) begin : g_hole
      assign flat[g*DW +: DW] = '0;
    end else begin : g_plain
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                q <= '0;
        else if (wr_en && g_sel == GSW'(g))        q <= wdata;
      end
      assign flat[g*DW +: DW] = q;
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < int'(NGLOB); g++)
      if (g_sel == GSW'(g)) rdata = flat[g*DW +: DW];
  end

endmodule

// File: rtl/dmac_stat_reg.sv
module dmac_stat_reg
  import dmac_rf_pkg::*;
#(
  parameter int unsigned NCH = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] ev_chan,
  input  logic           ev_stall,
  input  logic           ev_mfifo,
  input  logic           ev_berr,
  output logic [DW-1:0]  stat_q,
  output logic           irq
);

  logic [DW-1:0] set_vec;

  always_comb begin
    set_vec              = '0;
    set_vec[NCH-1:0]     = ev_chan;
    set_vec[STALL_BIT]   = ev_stall;
    set_vec[MFIFO_BIT]   = ev_mfifo;
    set_vec[BERR_BIT]    = ev_berr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_next(stat_q, wr_en, wdata, set_vec, NCH);
  end

  assign irq = stat_irq(stat_q, NCH);

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_rf_pkg::*;
#(
  parameter int unsigned NCH = 10,
  parameter int unsigned AW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic [NCH-1:0] ev_chan_done,
  input  logic           ev_stall,
  input  logic           ev_mfifo_empty,
  input  logic           ev_bus_err,
  output logic           irq
);

  localparam int unsigned CHW = $clog2(NCH);
  localparam int unsigned RSW = $clog2(NREG);
  localparam int unsigned GSW = $clog2(NGLOB + 1);

  // Decode events, named for the checker.
  logic           is_glob, lo_zero, ch_mid_zero, gl_mid_zero;
  logic           ch_hit, gl_hit, st_sel;
  logic           ch_wr, gl_wr, st_wr;
  logic [CHW-1:0] ch_sel;
  logic [RSW-1:0] reg_sel;
  logic [GSW-1:0] g_sel;
  logic [DW-1:0]  ch_rd, gl_rd, stat_q;

  assign is_glob     = reg_addr[AW-1];
  assign lo_zero     = (reg_addr[3:0] == 4'h0);
  assign ch_mid_zero = (reg_addr[AW-2:8+CHW] == '0);
  assign gl_mid_zero = (reg_addr[AW-2:4+GSW] == '0);
  assign ch_sel      = reg_addr[8 +: CHW];
  assign reg_sel     = reg_addr[4 +: RSW];
  assign g_sel       = reg_addr[4 +: GSW];

  assign ch_hit = !is_glob && lo_zero && ch_mid_zero;
  assign gl_hit =  is_glob && lo_zero && gl_mid_zero;
  assign st_sel = gl_hit && (g_sel == GSW'(GSTAT_IDX));
  assign ch_wr  = reg_we && ch_hit;
  assign gl_wr  = reg_we && gl_hit && !st_sel;
  assign st_wr  = reg_we && st_sel;

  dmac_chan_bank #(.NCH(NCH)) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ch_wr),
    .ch_sel  (ch_sel),
    .reg_sel (reg_sel),
    .wdata   (reg_wdata),
    .rdata   (ch_rd)
  );

  dmac_glob_regs u_glob (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (gl_wr),
    .g_sel (g_sel),
    .wdata (reg_wdata),
    .rdata (gl_rd)
  );

  dmac_stat_reg #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_wr),
    .wdata    (reg_wdata),
    .ev_chan  (ev_chan_done),
    .ev_stall (ev_stall),
    .ev_mfifo (ev_mfifo_empty),
    .ev_berr  (ev_bus_err),
    .stat_q   (stat_q),
    .irq      (irq)
  );

  always_comb begin
    if (st_sel)      reg_rdata = stat_q;
    else if (gl_hit) reg_rdata = gl_rd;
    else if (ch_hit) reg_rdata = ch_rd;
    else             reg_rdata = '0;
  end

endmodule

// File: rtl/dmac_rf_chk.sv
module dmac_rf_chk
  import dmac_rf_pkg::*;
#(
  parameter int unsigned NCH = 10,
  parameter int unsigned AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  reg_addr,
  input logic [31:0]    reg_wdata,
  input logic [31:0]    reg_rdata,
  input logic           ev_stall,
  input logic           ev_bus_err,
  input logic           irq,
  input logic           st_wr,
  input logic [31:0]    stat_q
);

  localparam logic [31:0] VMASK = stat_valid(NCH);

  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (stat_q == 32'h0 && !irq));

  p_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_addr[AW-1] && reg_addr[7:4] == 4'd6) |-> reg_rdata == 32'h0);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[BERR_BIT] && !ev_bus_err) |=> !stat_q[BERR_BIT]);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && !ev_bus_err) |=> $stable(stat_q[BERR_BIT]));

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[STALL_MSK]) |=> stat_q[STALL_MSK] != $past(stat_q[STALL_MSK]));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> $stable(stat_q[31:16]));

  p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~VMASK) == 32'h0);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> stat_q[STALL_BIT]);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q[30:16] != 15'h0 && stat_q[14:0] != 15'h0));

endmodule

bind dmac_regfile dmac_rf_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .ev_stall   (ev_stall),
  .ev_bus_err (ev_bus_err),
  .irq        (irq),
  .st_wr      (st_wr),
  .stat_q     (stat_q)
);

// File: tb/dmac_regfile_tb.sv
`timescale 1ns/1ps
module dmac_regfile_tb;

  localparam int NCH = 10;
  localparam logic [31:0] VALID = 32'h63FF_E3FF;
  localparam logic [15:0] STAT_A = 16'h8010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  ev_chan_done = '0;
  logic        ev_stall = 1'b0, ev_mfifo_empty = 1'b0, ev_bus_err = 1'b0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] sm = '0;   // bench status model

  always #2 clk = ~clk;

  dmac_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_chan_done(ev_chan_done),
    .ev_stall(ev_stall), .ev_mfifo_empty(ev_mfifo_empty),
    .ev_bus_err(ev_bus_err), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(string req, logic [15:0] a, logic [31:0] exp);
    reg_addr = a; #1; chk(req, reg_rdata, exp);
  endtask

  function automatic logic [15:0] ch_a(int c, int k);
    return 16'(c * 256 + k * 16);
  endfunction

  function automatic logic [31:0] pat(int c, int k);
    return 32'h8000_0000 | 32'(c << 20) | 32'(k << 12) | 32'h0000_0A5C | 32'(c * 7 + k);
  endfunction

  function automatic logic [31:0] ch_exp(int c, int k);
    if (k == 6 || k == 7) return 32'h0;
    if (k >= 3 && k <= 5) return pat(c, k) & 32'h7FFF_FFFF;
    return pat(c, k);
  endfunction

  function automatic logic [31:0] gpat(int g);
    return 32'hC3C3_0000 ^ 32'(g * 32'h0011_1111);
  endfunction

  // Model: low half drops written ones, high half flips written ones.
  function automatic logic [31:0] m_wr(logic [31:0] cur, logic [31:0] w);
    logic [31:0] r;
    r[15:0]  = cur[15:0] & ~w[15:0];
    r[31:16] = cur[31:16] ^ w[31:16];
    return r & VALID;
  endfunction

  function automatic logic m_irq(logic [31:0] s);
    logic e = 1'b0;
    for (int c = 0; c < NCH; c++) if (s[c] && s[16 + c]) e = 1'b1;
    if (s[13] && s[29]) e = 1'b1;
    if (s[14] && s[30]) e = 1'b1;
    return e;
  endfunction

  task automatic swr(string req, logic [31:0] w);
    wr(STAT_A, w); sm = m_wr(sm, w);
    rd(req, STAT_A, sm);
    chk(req, {31'h0, irq}, {31'h0, m_irq(sm)});
  endtask

  task automatic pulse(string req, logic [9:0] ch, logic st, logic mf, logic be);
    @(negedge clk);
    ev_chan_done = ch; ev_stall = st; ev_mfifo_empty = mf; ev_bus_err = be;
    @(negedge clk);
    ev_chan_done = '0; ev_stall = 0; ev_mfifo_empty = 0; ev_bus_err = 0;
    sm = (sm | {16'h0, be, mf, st, 3'b000, ch}) & VALID;
    rd(req, STAT_A, sm);
    chk(req, {31'h0, irq}, {31'h0, m_irq(sm)});
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 9; k++) rd("R1", ch_a(c, k), 32'h0);
    for (int g = 0; g < 8; g++) rd("R1", 16'(16'h8000 + g * 16), 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 R3 R4 channel sweep
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 9; k++) wr(ch_a(c, k), pat(c, k));
    for (int k = 9; k < 16; k++) wr(ch_a(0, k), 32'hFFFF_FFFF);
    for (int c = NCH; c < 16; c++) wr(ch_a(c, 0), 32'hFFFF_FFFF);
    wr(16'h1000, 32'hDEAD_BEEF);   // nonzero ignored bit 12 (R4)
    wr(16'h0004, 32'hDEAD_BEEF);   // nonzero byte offset (R4)
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 9; k++)
        rd((k == 6 || k == 7) ? "R4" : ((k >= 3 && k <= 5) ? "R3" : "R2"),
           ch_a(c, k), ch_exp(c, k));
    for (int k = 9; k < 16; k++) rd("R4", ch_a(0, k), 32'h0);
    for (int c = NCH; c < 16; c++) rd("R4", ch_a(c, 0), 32'h0);
    rd("R4", 16'h1000, 32'h0);
    rd("R4", 16'h0004, 32'h0);

    // R5 globals
    for (int g = 0; g < 8; g++) if (g != 1) wr(16'(16'h8000 + g * 16), gpat(g));
    for (int g = 0; g < 8; g++)
      if (g != 1) rd("R5", 16'(16'h8000 + g * 16), (g == 7) ? 32'h0 : gpat(g));
    rd("R5 status untouched", STAT_A, 32'h0);

    // R7 R8 toggle all masks from zero
    swr("R7", 32'hFFFF_FFFF);
    chk("R8", sm, 32'h63FF_0000);
    // R9 set all flags
    pulse("R9", 10'h3FF, 1, 1, 1);
    chk("R10", {31'h0, irq}, 32'h1);
    // R6 one-hot clear sweep, R7 one-hot toggle sweep
    for (int b = 0; b < 16; b++) swr("R6", 32'h1 << b);
    for (int b = 16; b < 32; b++) begin
      swr("R7", 32'h1 << b);
      swr("R7", 32'h1 << b);
    end
    swr("R8", 32'hFFFF_FFFF);   // masks back to zero, flags already clear
    chk("R8", sm, 32'h0);

    // R10 per-source interrupt sweep
    for (int c = 0; c < NCH; c++) begin
      swr("R10", 32'h1 << (16 + c));
      pulse("R10", 10'(1 << c), 0, 0, 0);
      swr("R10", 32'h1 << c);
      pulse("R10", 10'h3FF & ~10'(1 << c), 0, 0, 0);   // other flags, no irq
      swr("R10", 32'h0000_03FF);
      swr("R10", 32'h1 << (16 + c));
    end
    swr("R10", 32'h2000_0000); pulse("R10", 10'h0, 1, 0, 0); swr("R10", 32'h2000_2000);
    swr("R10", 32'h4000_0000); pulse("R10", 10'h0, 0, 1, 0); swr("R10", 32'h4000_4000);
    swr("R10", 32'h63FF_0000);
    pulse("R10 bus error", 10'h0, 0, 0, 1);
    chk("R10 bus error", {31'h0, irq}, 32'h0);
    swr("R6", 32'h63FF_8000);

    // R9 set wins over same-cycle clear
    pulse("R9", 10'h009, 0, 0, 0);
    @(negedge clk);
    reg_we = 1; reg_addr = STAT_A; reg_wdata = 32'h0000_0009; ev_chan_done = 10'h008;
    @(negedge clk);
    reg_we = 0; ev_chan_done = '0;
    sm = (m_wr(sm, 32'h0000_0009) | 32'h8) & VALID;
    rd("R9 set wins", STAT_A, sm);
    chk("R9", sm & 32'hF, 32'h8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule